// File: doc/BRIEF.md
# NOR Flash Word-Range Programmer

This block programs a run of consecutive words into a parallel NOR flash from the host side. After a start pulse it latches a base address and a word count. For each word it writes the three-cycle unlock-and-program command preamble, then writes the data word to its target address. It then reads the target repeatedly until the device's status bit shows that the internal program step has finished. A final read-back confirms the whole word before the controller moves on to the next address.

The data comes from an external source indexed by word offset, for example a block RAM. The source presents the word for `src_idx_o` one cycle after the index changes. The flash bus is a simple synchronous strobe bus: one-cycle write pulses, and one-cycle read pulses whose data must be valid in the following cycle. The run ends with `done_o` when every word has verified. It ends with `err_o` and the offending address on `err_addr_o` when a read-back differs or when the status bit never settles within the poll budget.

Top module: `nor_prog_ctrl`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `err_o`, `fl_we_o` and `fl_re_o` are all 0.
- R2: Each word starts with four flash writes in this order: address 0x555 data 0x00AA, address 0x2AA data 0x0055, address 0x555 data 0x00A0. The fourth write puts the source word on the target address.
- R3: `fl_we_o` and `fl_re_o` are never high together, and every write or read strobe lasts exactly one cycle.
- R4: After the data write, the controller reads the target address until bit 7 of the read data equals bit 7 of the written word.
- R5: After polling completes, one more read of the target is made, and all bits of the word are compared with the written word.
- R6: Word k (k = 0 .. length-1) goes to address base+k in ascending order and carries the source word for index k.
- R7: When the last word verifies, `done_o` rises while `busy_o` and `err_o` are 0. `done_o` stays high until the next accepted start.
- R8: A verify mismatch raises `err_o`, places the failing address on `err_addr_o`, drops `busy_o` and stops all further flash writes.
- R9: The controller issues at most POLL_MAX status reads per word. If the POLL_MAX-th read still shows the program step as unfinished, it stops as in R8, with the target address on `err_addr_o`. If that read shows completion, the word proceeds normally.
- R10: A start pulse while `busy_o` is high is ignored.
- R11: A start with length 0 sets `done_o` in the next cycle and makes no flash access.
- R12: A start accepted after an error or a completed run clears `err_o` and `done_o` and runs the new range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_addr_i | input | AW | First flash word address |
| length_i | input | LW | Number of words to program |
| src_idx_o | output | LW | Word offset requested from the data source |
| src_data_i | input | DW | Source word for `src_idx_o`, valid one cycle after it changes |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | DW | Flash write data |
| fl_we_o | output | 1 | Flash write strobe (one cycle) |
| fl_re_o | output | 1 | Flash read strobe (one cycle) |
| fl_rdata_i | input | DW | Flash read data, valid the cycle after `fl_re_o` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed without error |
| err_o | output | 1 | Last run stopped on mismatch or poll timeout |
| err_addr_o | output | AW | Flash address where the run stopped |

## Verification
Completion detection and the poll-budget timeout are both decided from the same status read, so they can fall in the same cycle. The bench provokes this by making the behavioural flash report "still busy" for exactly POLL_MAX-1 reads, so completion shows on the last allowed read. That run must finish without error. Setting the busy count to POLL_MAX on a single address must then give a timeout error naming that address. A second collision is a start pulse arriving mid-run. It is judged by checking that the area the second start requested is left erased.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_W,
    ST_CMD_G,
    ST_POLL_R,
    ST_POLL_D,
    ST_VER_R,
    ST_VER_D
  } prog_st_e;

  localparam logic [7:0] CB_KEY1 = 8'hAA;
  localparam logic [7:0] CB_KEY2 = 8'h55;
  localparam logic [7:0] CB_PGM  = 8'hA0;
  localparam logic [1:0] STEP_DATA = 2'd3;
endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_prog_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] KEY_A1 = AW'(12'h555),
  parameter logic [AW-1:0] KEY_A2 = AW'(12'h2AA)
) (
  input  logic [1:0]    step_i,
  input  logic [AW-1:0] target_i,
  input  logic [DW-1:0] word_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_comb begin
    case (step_i)
      2'd0:    begin addr_o = KEY_A1;   data_o = DW'(CB_KEY1); end
      2'd1:    begin addr_o = KEY_A2;   data_o = DW'(CB_KEY2); end
      2'd2:    begin addr_o = KEY_A1;   data_o = DW'(CB_PGM);  end
      default: begin addr_o = target_i; data_o = word_i;       end
    endcase
  end
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int POLL_MAX = 1024,
  localparam int CW = $clog2(POLL_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic bump_i,
  output logic spent_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= CW'(1);
    else if (bump_i) cnt_q <= cnt_q + CW'(1);
  end

  assign spent_o = (cnt_q == CW'(POLL_MAX));
endmodule

// File: rtl/nor_word_walker.sv
module nor_word_walker #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_i,
  input  logic          adv_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] idx_o,
  output logic          last_o
);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      idx_o  <= '0;
      left_q <= '0;
    end else if (init_i) begin
      addr_o <= base_i;
      idx_o  <= '0;
      left_q <= len_i;
    end else if (adv_i) begin
      addr_o <= addr_o + AW'(1);
      idx_o  <= idx_o + LW'(1);
      left_q <= left_q - LW'(1);
    end
  end

  assign last_o = (left_q == LW'(1));
endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
  import nor_prog_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int LW       = 8,
  parameter int POLL_MAX = 1024,
  parameter logic [AW-1:0] KEY_A1 = AW'(12'h555),
  parameter logic [AW-1:0] KEY_A2 = AW'(12'h2AA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [LW-1:0] length_i,
  output logic [LW-1:0] src_idx_o,
  input  logic [DW-1:0] src_data_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  output logic          fl_we_o,
  output logic          fl_re_o,
  input  logic [DW-1:0] fl_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] err_addr_o
);
  prog_st_e      st_q;
  logic [1:0]    step_q;
  logic [DW-1:0] word_q;
  logic [1:0]    rom_step;
  logic [AW-1:0] rom_addr, tgt_addr;
  logic [DW-1:0] rom_data;
  logic          go, walk_adv, walk_last;
  logic          tmr_load, tmr_bump, tmr_spent;
  logic          poll_hit, ver_ok;

  assign go       = (st_q == ST_IDLE) && start_i && (length_i != '0);
  assign poll_hit = (fl_rdata_i[7] == word_q[7]);
  assign ver_ok   = (fl_rdata_i == word_q);
  assign walk_adv = (st_q == ST_VER_D) && ver_ok && !walk_last;
  assign tmr_load = (st_q == ST_CMD_G) && (step_q == STEP_DATA);
  assign tmr_bump = (st_q == ST_POLL_D) && !poll_hit && !tmr_spent;
  assign rom_step = (st_q == ST_CMD_G) ? step_q + 2'd1 : 2'd0;

  nor_cmd_rom #(.AW(AW), .DW(DW), .KEY_A1(KEY_A1), .KEY_A2(KEY_A2)) u_rom (
    .step_i(rom_step), .target_i(tgt_addr), .word_i(src_data_i),
    .addr_o(rom_addr), .data_o(rom_data)
  );

  nor_poll_timer #(.POLL_MAX(POLL_MAX)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .bump_i(tmr_bump), .spent_o(tmr_spent)
  );

  nor_word_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst(rst), .init_i(go), .adv_i(walk_adv),
    .base_i(base_addr_i), .len_i(length_i),
    .addr_o(tgt_addr), .idx_o(src_idx_o), .last_o(walk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      step_q     <= '0;
      word_q     <= '0;
      fl_addr_o  <= '0;
      fl_wdata_o <= '0;
      fl_we_o    <= 1'b0;
      fl_re_o    <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_addr_o <= '0;
    end else begin
      fl_we_o <= 1'b0;
      fl_re_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          err_o <= 1'b0;
          if (length_i == '0) begin
            done_o <= 1'b1;
          end else begin
            done_o     <= 1'b0;
            busy_o     <= 1'b1;
            step_q     <= 2'd0;
            fl_we_o    <= 1'b1;
            fl_addr_o  <= rom_addr;
            fl_wdata_o <= rom_data;
            st_q       <= ST_CMD_W;
          end
        end
        ST_CMD_W: st_q <= ST_CMD_G;
        ST_CMD_G: begin
          if (step_q == STEP_DATA) begin
            fl_re_o   <= 1'b1;
            fl_addr_o <= tgt_addr;
            st_q      <= ST_POLL_R;
          end else begin
            step_q     <= rom_step;
            fl_we_o    <= 1'b1;
            fl_addr_o  <= rom_addr;
            fl_wdata_o <= rom_data;
            if (rom_step == STEP_DATA) word_q <= src_data_i;
            st_q       <= ST_CMD_W;
          end
        end
        ST_POLL_R: st_q <= ST_POLL_D;
        ST_POLL_D: begin
          if (poll_hit) begin
            fl_re_o <= 1'b1;
            st_q    <= ST_VER_R;
          end else if (tmr_spent) begin
            err_o      <= 1'b1;
            err_addr_o <= tgt_addr;
            busy_o     <= 1'b0;
            st_q       <= ST_IDLE;
          end else begin
            fl_re_o <= 1'b1;
            st_q    <= ST_POLL_R;
          end
        end
        ST_VER_R: st_q <= ST_VER_D;
        ST_VER_D: begin
          if (!ver_ok) begin
            err_o      <= 1'b1;
            err_addr_o <= tgt_addr;
            busy_o     <= 1'b0;
            st_q       <= ST_IDLE;
          end else if (walk_last) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            step_q     <= 2'd0;
            fl_we_o    <= 1'b1;
            fl_addr_o  <= rom_addr;
            fl_wdata_o <= rom_data;
            st_q       <= ST_CMD_W;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_prog_chk.sv
module nor_prog_chk #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [LW-1:0] length_i,
  input logic          fl_we_o,
  input logic          fl_re_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] err_addr_o
);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fl_we_o && fl_re_o));
  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fl_we_o |=> !fl_we_o);
  // R3
  re_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fl_re_o |=> !fl_re_o);
  // R7
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!err_o && !busy_o));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && !fl_we_o));
  // R8
  err_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> $stable(err_addr_o));
  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && length_i == '0) |=> (done_o && !busy_o));
endmodule

bind nor_prog_ctrl nor_prog_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .length_i(length_i),
  .fl_we_o(fl_we_o), .fl_re_o(fl_re_o), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .err_addr_o(err_addr_o)
);

// File: tb/nor_prog_ctrl_tb.sv
module nor_prog_ctrl_tb;
  localparam int AW = 16, DW = 16, LW = 8, PM = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] len = '0;
  logic [LW-1:0] src_idx;
  logic [DW-1:0] src_q = '0;
  logic [AW-1:0] fa;
  logic [DW-1:0] fwd, rd_q;
  logic fwe, fre, busy, done, err;
  logic [AW-1:0] eaddr;

  always #4 clk = ~clk;

  nor_prog_ctrl #(.AW(AW), .DW(DW), .LW(LW), .POLL_MAX(PM)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .base_addr_i(base), .length_i(len),
    .src_idx_o(src_idx), .src_data_i(src_q), .fl_addr_o(fa), .fl_wdata_o(fwd),
    .fl_we_o(fwe), .fl_re_o(fre), .fl_rdata_i(rd_q), .busy_o(busy), .done_o(done),
    .err_o(err), .err_addr_o(eaddr)
  );

  // stimulus knobs, written only from the initial block
  logic [15:0] seed = 16'h0;
  int busy_cfg = 2;
  logic [AW-1:0] hang_a = 16'hFFFF, bad_a = 16'hFFFF;
  logic erase_req = 1'b0;

  function automatic logic [15:0] pat(input logic [LW-1:0] k, input logic [15:0] s);
    return 16'hA5C3 ^ (16'(k) * 16'h1357) ^ s;
  endfunction

  always @(posedge clk) src_q <= pat(src_idx, seed);

  // behavioural flash
  logic [15:0] mem [0:255];
  int seq = 0, seq_bad = 0, n_wr = 0, n_pgm = 0, n_rd = 0, strobe_bad = 0;
  logic [AW-1:0] log_a [0:63];
  logic [15:0]   log_d [0:63];
  logic [AW-1:0] pend_a = 16'hFFFF;
  int busy_left = 0;
  logic we_d = 1'b0;

  always @(posedge clk) begin
    we_d <= fwe;
    if ((fwe && fre) || (fwe && we_d)) strobe_bad <= strobe_bad + 1;
    if (erase_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'hFFFF;
    end else if (fwe) begin
      n_wr <= n_wr + 1;
      case (seq)
        0: begin if (fa != 16'h555 || fwd != 16'h00AA) seq_bad <= seq_bad + 1; seq <= 1; end
        1: begin if (fa != 16'h2AA || fwd != 16'h0055) seq_bad <= seq_bad + 1; seq <= 2; end
        2: begin if (fa != 16'h555 || fwd != 16'h00A0) seq_bad <= seq_bad + 1; seq <= 3; end
        default: begin
          seq <= 0;
          mem[fa[7:0]] <= (fa == bad_a) ? (fwd ^ 16'h0100) : fwd;
          if (n_pgm < 64) begin log_a[n_pgm] <= fa; log_d[n_pgm] <= fwd; end
          n_pgm <= n_pgm + 1;
          pend_a <= fa;
          busy_left <= (fa == hang_a) ? 1000 : busy_cfg;
        end
      endcase
    end
    if (fre) begin
      n_rd <= n_rd + 1;
      if (fa == pend_a && busy_left != 0) begin
        rd_q <= mem[fa[7:0]] ^ 16'h0080;
        busy_left <= busy_left - 1;
      end else rd_q <= mem[fa[7:0]];
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic erase();
    @(negedge clk) erase_req = 1'b1;
    @(negedge clk) erase_req = 1'b0;
  endtask

  task automatic launch(input logic [AW-1:0] b, input logic [LW-1:0] l);
    @(negedge clk);
    base = b; len = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (!(done || err) && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !fwe && !fre, "R1 reset state",
        {busy, done, err, fwe, fre}, 0);
  endtask

  task automatic t_basic();
    int p0 = n_pgm, w0 = n_wr, r0 = n_rd;
    bit ord_ok = 1'b1, mem_ok = 1'b1;
    erase(); busy_cfg = 3; seed = 16'h0;
    launch(16'h0020, 8'd4);
    wait_end();
    chk(done && !err && !busy, "R7 done after last word", {done, err, busy}, 3'b100);
    chk(seq_bad == 0, "R2 command preamble", seq_bad, 0);
    chk(strobe_bad == 0, "R3 strobe shape", strobe_bad, 0);
    chk(n_wr - w0 == 16, "R2 four writes per word", n_wr - w0, 16);
    for (int k = 0; k < 4; k++) begin
      if (log_a[p0+k] != 16'h0020 + 16'(k) || log_d[p0+k] != pat(LW'(k), seed)) ord_ok = 1'b0;
      if (mem[8'h20 + 8'(k)] != pat(LW'(k), seed)) mem_ok = 1'b0;
    end
    chk(ord_ok, "R6 ascending addresses and indexed data", ord_ok, 1);
    chk(mem_ok, "R6 array contents", mem_ok, 1);
    // R4 R5: 3 busy polls + 1 completing poll + 1 verify read per word
    chk(n_rd - r0 == 4 * 5, "R4 R5 read count", n_rd - r0, 20);
    repeat (20) @(negedge clk);
    chk(done && !busy, "R7 done held", done, 1);
  endtask

  task automatic t_poll_edge();
    int r0 = n_rd, w0;
    erase(); busy_cfg = PM - 1; seed = 16'h5A5A;
    launch(16'h0030, 8'd2);
    wait_end();
    chk(done && !err, "R9 completion on last allowed poll", {done, err}, 2'b10);
    chk(n_rd - r0 == 2 * (PM + 1), "R4 poll reads at budget", n_rd - r0, 2 * (PM + 1));
    erase(); busy_cfg = 1; hang_a = 16'h0041;
    w0 = n_wr; r0 = n_rd;
    launch(16'h0040, 8'd3);
    wait_end();
    chk(err && !done && !busy, "R9 timeout error", {err, done, busy}, 3'b100);
    chk(eaddr == 16'h0041, "R9 timeout address", eaddr, 16'h0041);
    // word 0: 2 polls + verify; word 1: PM polls
    chk(n_rd - r0 == 3 + PM, "R9 poll budget", n_rd - r0, 3 + PM);
    repeat (10) @(negedge clk);
    chk(n_wr - w0 == 8, "R9 no writes after timeout", n_wr - w0, 8);
    hang_a = 16'hFFFF;
  endtask

  task automatic t_mismatch();
    int w0 = n_wr;
    erase(); busy_cfg = 2; bad_a = 16'h0062;
    launch(16'h0060, 8'd5);
    wait_end();
    chk(err && !done && !busy, "R8 mismatch error", {err, done, busy}, 3'b100);
    chk(eaddr == 16'h0062, "R5 R8 failing address", eaddr, 16'h0062);
    repeat (10) @(negedge clk);
    chk(n_wr - w0 == 12, "R8 no writes after mismatch", n_wr - w0, 12);
    chk(eaddr == 16'h0062, "R8 address held", eaddr, 16'h0062);
    bad_a = 16'hFFFF;
    launch(16'h0070, 8'd2);
    chk(busy && !err && !done, "R12 flags cleared on restart", {busy, err, done}, 3'b100);
    wait_end();
    chk(done && !err, "R12 rerun completes", {done, err}, 2'b10);
  endtask

  task automatic t_zero_len();
    int w0 = n_wr, r0 = n_rd;
    launch(16'h0090, 8'd0);
    chk(done && !busy && !err, "R11 zero length done", {done, busy, err}, 3'b100);
    repeat (5) @(negedge clk);
    chk(n_wr == w0 && n_rd == r0, "R11 no flash access", n_wr - w0 + n_rd - r0, 0);
  endtask

  task automatic t_busy_start();
    int p0 = n_pgm;
    erase(); busy_cfg = 2;
    launch(16'h0080, 8'd3);
    repeat (6) @(negedge clk);
    launch(16'h00C0, 8'd4);
    wait_end();
    chk(done && n_pgm - p0 == 3, "R10 second start ignored", n_pgm - p0, 3);
    chk(mem[8'hC0] == 16'hFFFF, "R10 other range untouched", mem[8'hC0], 16'hFFFF);
    chk(log_a[p0+2] == 16'h0082, "R10 original range finished", log_a[p0+2], 16'h0082);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_poll_edge();
    t_mismatch();
    t_zero_len();
    t_busy_start();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end
endmodule